// File: doc/BRIEF.md
# Serial RTC Bus Frame Master

This block talks to a real-time-clock device over four wires: an active-low chip select, an active-low write strobe, an active-low read strobe and one bidirectional data line. The data line is split into an output value, an output enable and an input. Every bit is its own strobe cycle, framed by chip select. A frame first sends a 4-bit register address, least significant bit first. It then either writes 8 data bits or reads 8 data bits, also least significant bit first. Some address values are commands. A command frame stops after its address bits.

On the user side there is a valid/ready request port with an address, write data, a read/write flag and a resync flag. The result comes back as a one-cycle done pulse with read data beside it. A resync request sends eight bare read strobes, so the device is aligned to expect a fresh frame. The bits read during a resync are thrown away.

The strobe width and the gap between bits come from the parameter `PHASE_CYC`, counted in system clock cycles. The default of 50 gives 1 µs at 50 MHz. The parameter `CMD_MASK` holds one bit per address value and marks which addresses are commands.

Top module: `rtc_frame_master`

## Requirements
- R1: While idle and after reset: `rtc_cs_n`, `rtc_wr_n` and `rtc_rd_n` are 1, `rtc_dq_oe` is 0, `req_ready` is 1 and `rsp_done` is 0. `rsp_rdata` resets to 0.
- R2: A normal frame (not a command, not a resync) starts with 4 write-bit cycles that carry `req_addr[0]` first and `req_addr[3]` last. In a write-bit cycle, `rtc_dq_oe` is 1 and `rtc_dq_o` holds the bit for as long as chip select is low.
- R3: When `req_write`=1, 8 write-bit cycles follow the address. They carry `req_wdata[0]` first and `req_wdata[7]` last.
- R4: When `req_write`=0, 8 read-bit cycles follow the address with `rtc_dq_oe`=0. The design samples `rtc_dq_i` on the last clock of the first `PHASE_CYC` cycles in which `rtc_rd_n` is low. The first bit sampled becomes `rsp_rdata[0]` and the eighth becomes `rsp_rdata[7]`.
- R5: When `CMD_MASK[req_addr]` is 1 and `req_resync`=0, the frame sends only the 4 address write-bit cycles, whatever the value of `req_write`.
- R6: Each bit cycle runs as follows: chip select goes low for 1 cycle with both strobes high. The strobe is then low for `PHASE_CYC` cycles for a write bit, or for 2·`PHASE_CYC` cycles for a read bit. Next comes 1 cycle with chip select still low and the strobe high. Last comes a gap of `PHASE_CYC` cycles with all three lines high and `rtc_dq_oe`=0. This gap also follows the final bit of a frame.
- R7: `req_resync`=1 takes priority over the other request fields. It produces 8 read-bit cycles with no address, and `rsp_rdata` stays at its previous value.
- R8: A request is accepted on a clock where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the final gap ends. `rsp_done` is 1 for exactly the first cycle after that gap, `req_ready` is 1 in that same cycle, and after a read frame `rsp_rdata` shows the new value in that cycle.
- R9: The two strobes are never low together, and neither strobe is low while chip select is high.
- R10: Changes to `req_addr`, `req_wdata`, `req_write`, `req_resync` and `req_valid` while `req_ready` is 0 have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and will accept a request |
| req_addr | input | ADDR_W | Register address or command code |
| req_wdata | input | DATA_W | Data for a register write |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_resync | input | 1 | Issue eight bare read strobes instead of a frame |
| rsp_done | output | 1 | One-cycle end-of-frame pulse |
| rsp_rdata | output | DATA_W | Data from the most recent read frame |
| rtc_cs_n | output | 1 | Chip select, active low |
| rtc_wr_n | output | 1 | Write strobe, active low |
| rtc_rd_n | output | 1 | Read strobe, active low |
| rtc_dq_o | output | 1 | Data line output value |
| rtc_dq_oe | output | 1 | Data line output enable |
| rtc_dq_i | input | 1 | Data line input value |

## Verification
The embedded properties assume a synchronous reset that is held for at least one clock edge. They also assume the request inputs are stable around the rising edge, so that acceptance depends only on `req_valid` and `req_ready`. The bench changes every request input on the falling edge, and it holds reset for several cycles before releasing it. The shift-register property assumes the device keeps `rtc_dq_i` steady until the sample edge. The bench's device model changes that line only on the first falling clock edge after a read strobe falls, which is at least `PHASE_CYC`-1 cycles before the sample.

// File: rtl/rtcf_pkg.sv
// Package rtcf_pkg
// Shared types for the serial RTC frame master: the bit-cycle phases and the
// frame kinds. Assumes no more than the four frame kinds listed here.
package rtcf_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_ACT,
        PH_TAIL,
        PH_GAP
    } phase_e;

    typedef enum logic [1:0] {
        FK_WRITE,
        FK_READ,
        FK_CMD,
        FK_RESYNC
    } frame_e;

endpackage

// File: rtl/rtcf_bit_engine.sv
// Module rtcf_bit_engine
// Runs one bit cycle at a time. The phases are lead (1 cycle), strobe active
// (PHASE_CYC cycles, or 2*PHASE_CYC for a read bit), tail (1 cycle) and gap
// (PHASE_CYC cycles). It flags the edge on which the read sample is taken and
// the end of every gap.
// Assumes bit_rd and bit_last are stable while a bit cycle is running.
module rtcf_bit_engine
    import rtcf_pkg::*;
#(
    parameter int PHASE_CYC = 50
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   bit_rd,
    input  logic   bit_last,
    output phase_e phase,
    output logic   sample,
    output logic   bit_next,
    output logic   frame_end
);

    localparam int CNT_W = $clog2(2 * PHASE_CYC + 1);
    localparam logic [CNT_W-1:0] HALF_END = CNT_W'(PHASE_CYC - 1);
    localparam logic [CNT_W-1:0] FULL_END = CNT_W'(2 * PHASE_CYC - 1);

    phase_e           ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic             act_done;
    logic             gap_done;

    assign act_done  = (ph_q == PH_ACT) && (cnt_q == (bit_rd ? FULL_END : HALF_END));
    assign gap_done  = (ph_q == PH_GAP) && (cnt_q == HALF_END);
    assign sample    = (ph_q == PH_ACT) && bit_rd && (cnt_q == HALF_END);
    assign bit_next  = gap_done && !bit_last;
    assign frame_end = gap_done && bit_last;
    assign phase     = ph_q;

    // Phase sequencer and per-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: if (start) ph_q <= PH_LEAD;
                PH_LEAD: begin
                    ph_q  <= PH_ACT;
                    cnt_q <= '0;
                end
                PH_ACT: begin
                    if (act_done) ph_q <= PH_TAIL;
                    else          cnt_q <= cnt_q + 1'b1;
                end
                PH_TAIL: begin
                    ph_q  <= PH_GAP;
                    cnt_q <= '0;
                end
                PH_GAP: begin
                    if (gap_done) ph_q <= bit_last ? PH_IDLE : PH_LEAD;
                    else          cnt_q <= cnt_q + 1'b1;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // R6: the strobe-active phase is only ever entered from the lead phase.
    assert_act_after_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_ACT && $past(ph_q) != PH_ACT) |-> $past(ph_q) == PH_LEAD);

    // R6: the gap is only ever entered from the tail phase.
    assert_gap_after_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_GAP && $past(ph_q) != PH_GAP) |-> $past(ph_q) == PH_TAIL);

endmodule

// File: rtl/rtcf_bit_sched.sv
// Module rtcf_bit_sched
// Combinational view of the current bit: its direction, its output value and
// whether it ends the frame. The choice depends on the frame kind and the bit
// index. Address bits come first, both groups least significant bit first.
// Assumes bidx never goes past the last bit of the frame kind.
module rtcf_bit_sched
    import rtcf_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  frame_e                                kind,
    input  logic [ADDR_W-1:0]                     addr,
    input  logic [DATA_W-1:0]                     wdata,
    input  logic [$clog2(ADDR_W+DATA_W+1)-1:0]    bidx,
    output logic                                  bit_rd,
    output logic                                  bit_val,
    output logic                                  bit_last
);

    localparam int IDX_W = $clog2(ADDR_W + DATA_W + 1);
    localparam logic [IDX_W-1:0] LAST_CMD  = IDX_W'(ADDR_W - 1);
    localparam logic [IDX_W-1:0] LAST_SYNC = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] LAST_FULL = IDX_W'(ADDR_W + DATA_W - 1);
    localparam logic [IDX_W-1:0] FIRST_DAT = IDX_W'(ADDR_W);

    logic [ADDR_W+DATA_W-1:0] stream;

    assign stream = {wdata, addr};

    // Decode direction, value and frame end for the current bit.
    always_comb begin
        bit_rd   = 1'b0;
        bit_val  = 1'b0;
        bit_last = 1'b0;
        unique case (kind)
            FK_RESYNC: begin
                bit_rd   = 1'b1;
                bit_last = (bidx == LAST_SYNC);
            end
            FK_CMD: begin
                bit_val  = stream[bidx];
                bit_last = (bidx == LAST_CMD);
            end
            FK_READ: begin
                bit_rd   = (bidx >= FIRST_DAT);
                bit_val  = bit_rd ? 1'b0 : stream[bidx];
                bit_last = (bidx == LAST_FULL);
            end
            default: begin
                bit_val  = stream[bidx];
                bit_last = (bidx == LAST_FULL);
            end
        endcase
    end

endmodule

// File: rtl/rtcf_rx_shift.sv
// Module rtcf_rx_shift
// Shift register for received bits. Each new bit enters at the top and the
// contents move right, so the first bit received ends up in bit 0.
// Assumes clear and sample are never both high in the same cycle.
module rtcf_rx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              din,
    output logic [DATA_W-1:0] data
);

    logic [DATA_W-1:0] sh_q;

    // Clear at frame start, otherwise shift right on every sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) sh_q <= '0;
        else if (sample)     sh_q <= {din, sh_q[DATA_W-1:1]};
    end

    assign data = sh_q;

    // R4: a sample moves the older bits one place toward bit 0.
    assert_shift_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !clear) |=> sh_q[DATA_W-2:0] == $past(sh_q[DATA_W-1:1]));

endmodule

// File: rtl/rtc_frame_master.sv
// Module rtc_frame_master
// Frame master for a four-wire serial RTC link. It accepts one request at a
// time, captures the request fields, and runs the bit cycles of the frame.
// When the frame ends it gives a one-cycle done pulse and, after a read frame,
// new read data.
// Assumes the external pad merges rtc_dq_o/rtc_dq_oe with rtc_dq_i.
module rtc_frame_master
    import rtcf_pkg::*;
#(
    parameter int                      ADDR_W    = 4,
    parameter int                      DATA_W    = 8,
    parameter int                      PHASE_CYC = 50,
    parameter logic [(1<<ADDR_W)-1:0]  CMD_MASK  = 16'hF000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_resync,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rtc_cs_n,
    output logic              rtc_wr_n,
    output logic              rtc_rd_n,
    output logic              rtc_dq_o,
    output logic              rtc_dq_oe,
    input  logic              rtc_dq_i
);

    localparam int IDX_W = $clog2(ADDR_W + DATA_W + 1);

    frame_e            kind_q;
    frame_e            kind_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [IDX_W-1:0]  bidx_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;
    logic              accept;
    phase_e            phase;
    logic              sample;
    logic              bit_next;
    logic              frame_end;
    logic              bit_rd;
    logic              bit_val;
    logic              bit_last;
    logic              cs_act;
    logic [DATA_W-1:0] rx_data;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    // Frame kind decode: resync first, then the command mask, then direction.
    always_comb begin
        if (req_resync)              kind_d = FK_RESYNC;
        else if (CMD_MASK[req_addr]) kind_d = FK_CMD;
        else if (req_write)          kind_d = FK_WRITE;
        else                         kind_d = FK_READ;
    end

    // Capture the request fields on acceptance and step the bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= FK_WRITE;
            addr_q  <= '0;
            wdata_q <= '0;
            bidx_q  <= '0;
        end else if (accept) begin
            kind_q  <= kind_d;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            bidx_q  <= '0;
        end else if (bit_next) begin
            bidx_q  <= bidx_q + 1'b1;
        end
    end

    // Registered done pulse, and read data kept after read frames only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= frame_end;
            if (frame_end && kind_q == FK_READ) rdata_q <= rx_data;
        end
    end

    rtcf_bit_sched #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_sched (
        .kind     (kind_q),
        .addr     (addr_q),
        .wdata    (wdata_q),
        .bidx     (bidx_q),
        .bit_rd   (bit_rd),
        .bit_val  (bit_val),
        .bit_last (bit_last)
    );

    rtcf_bit_engine #(
        .PHASE_CYC (PHASE_CYC)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .bit_rd    (bit_rd),
        .bit_last  (bit_last),
        .phase     (phase),
        .sample    (sample),
        .bit_next  (bit_next),
        .frame_end (frame_end)
    );

    rtcf_rx_shift #(
        .DATA_W (DATA_W)
    ) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .sample (sample),
        .din    (rtc_dq_i),
        .data   (rx_data)
    );

    assign cs_act    = (phase == PH_LEAD) || (phase == PH_ACT) || (phase == PH_TAIL);
    assign rtc_cs_n  = !cs_act;
    assign rtc_wr_n  = !((phase == PH_ACT) && !bit_rd);
    assign rtc_rd_n  = !((phase == PH_ACT) && bit_rd);
    assign rtc_dq_oe = cs_act && !bit_rd;
    assign rtc_dq_o  = rtc_dq_oe && bit_val;
    assign rsp_done  = done_q;
    assign rsp_rdata = rdata_q;

    // R9: the write and read strobes are never low together.
    assert_strobe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rtc_wr_n && !rtc_rd_n));

    // R9: a strobe is low only while chip select is low.
    assert_strobe_under_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rtc_wr_n || !rtc_rd_n) |-> !rtc_cs_n);

    // R6: chip select was already low in the cycle before a strobe falls.
    assert_cs_leads_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rtc_wr_n) || $fell(rtc_rd_n)) |-> $past(!rtc_cs_n));

    // R8: an accepted request takes ready low on the next cycle.
    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8: done lasts one cycle and comes only while ready is high.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (req_ready && !$past(rsp_done)));

    // R4: the data driver is off while the read strobe is low.
    assert_released_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rtc_rd_n |-> !rtc_dq_oe);

    // R1: chip select is high and the driver is off whenever the block is idle.
    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (rtc_cs_n && !rtc_dq_oe));

endmodule

// File: tb/rtc_frame_master_bench.sv
// Bench for rtc_frame_master. A behavioural model builds a queue with one
// expected entry per clock cycle for each accepted request. Every cycle the
// outputs are compared with the head entry on the falling edge.
module rtc_frame_master_bench;

    localparam int P = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [3:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       req_write = 1'b0;
    logic       req_resync = 1'b0;
    logic       rsp_done;
    logic [7:0] rsp_rdata;
    logic       rtc_cs_n, rtc_wr_n, rtc_rd_n, rtc_dq_o, rtc_dq_oe;
    logic       rtc_dq_i = 1'b0;

    int   vectors = 0;
    int   fails = 0;
    bit   finished = 1'b0;
    logic [7:0] dev_byte = '0;
    int   rd_cnt = 0;
    bit   rd_prev = 1'b0;
    string tag_override = "";

    always #10 clk = ~clk;

    rtc_frame_master #(
        .PHASE_CYC (P)
    ) u_rtc_frame_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_write  (req_write),
        .req_resync (req_resync),
        .rsp_done   (rsp_done),
        .rsp_rdata  (rsp_rdata),
        .rtc_cs_n   (rtc_cs_n),
        .rtc_wr_n   (rtc_wr_n),
        .rtc_rd_n   (rtc_rd_n),
        .rtc_dq_o   (rtc_dq_o),
        .rtc_dq_oe  (rtc_dq_oe),
        .rtc_dq_i   (rtc_dq_i)
    );

    typedef struct {
        bit cs, wr, rd, oe, dq, rdy, dn;
        logic [7:0] rd8;
        string tag;
    } cyc_t;

    cyc_t exq[$];
    cyc_t cur;
    logic [7:0] m_rdata = '0;

    function automatic cyc_t idle_cyc(logic [7:0] r, bit dn, string t);
        cyc_t c;
        c = '{cs:1, wr:1, rd:1, oe:0, dq:0, rdy:1, dn:dn, rd8:r, tag:t};
        return c;
    endfunction

    // One bit cycle: lead, strobe, tail, gap.
    function automatic void add_bit(bit rdb, bit v, string t);
        string tt;
        tt = (tag_override != "") ? tag_override : t;
        exq.push_back('{cs:0, wr:1, rd:1, oe:!rdb, dq:v & !rdb, rdy:0, dn:0, rd8:m_rdata, tag:"R6"});
        for (int n = 0; n < (rdb ? 2 * P : P); n++)
            exq.push_back('{cs:0, wr:rdb, rd:!rdb, oe:!rdb, dq:v & !rdb, rdy:0, dn:0, rd8:m_rdata, tag:tt});
        exq.push_back('{cs:0, wr:1, rd:1, oe:!rdb, dq:v & !rdb, rdy:0, dn:0, rd8:m_rdata, tag:"R6"});
        for (int n = 0; n < P; n++)
            exq.push_back('{cs:1, wr:1, rd:1, oe:0, dq:0, rdy:0, dn:0, rd8:m_rdata, tag:"R6"});
    endfunction

    // Expected frame for the request accepted on this edge.
    function automatic void push_frame();
        bit is_cmd;
        is_cmd = (req_addr >= 4'd12);
        if (req_resync) begin
            for (int i = 0; i < 8; i++) add_bit(1'b1, 1'b0, "R7");
            exq.push_back(idle_cyc(m_rdata, 1'b1, "R7"));
        end else begin
            for (int i = 0; i < 4; i++) add_bit(1'b0, req_addr[i], is_cmd ? "R5" : "R2");
            if (is_cmd) begin
                exq.push_back(idle_cyc(m_rdata, 1'b1, "R5"));
            end else if (req_write) begin
                for (int i = 0; i < 8; i++) add_bit(1'b0, req_wdata[i], "R3");
                exq.push_back(idle_cyc(m_rdata, 1'b1, "R8"));
            end else begin
                for (int i = 0; i < 8; i++) add_bit(1'b1, 1'b0, "R4");
                exq.push_back(idle_cyc(dev_byte, 1'b1, "R8"));
            end
        end
    endfunction

    // Reference model: pick this cycle's expected outputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            exq.delete();
            m_rdata = '0;
            cur = idle_cyc('0, 1'b0, "R1");
        end else begin
            if (cur.rdy && req_valid) push_frame();
            if (exq.size() > 0) cur = exq.pop_front();
            else                cur = idle_cyc(m_rdata, 1'b0, "R1");
            m_rdata = cur.rd8;
        end
    end

    // Device model: present the next bit of dev_byte on each read strobe.
    always @(negedge clk) begin
        if (rtc_rd_n === 1'b0 && !rd_prev) begin
            rtc_dq_i = dev_byte[rd_cnt % 8];
            rd_cnt++;
        end
        rd_prev = (rtc_rd_n === 1'b0);
    end

    task automatic cmp(string nm, logic [7:0] act, logic [7:0] exp, string t);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", t, nm, act, exp, $time);
        end
    endtask

    // Compare every output with the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            vectors++;
            cmp("cs_n",  {7'd0, rtc_cs_n},  {7'd0, cur.cs},  cur.tag);
            cmp("wr_n",  {7'd0, rtc_wr_n},  {7'd0, cur.wr},  cur.tag);
            cmp("rd_n",  {7'd0, rtc_rd_n},  {7'd0, cur.rd},  cur.tag);
            cmp("dq_oe", {7'd0, rtc_dq_oe}, {7'd0, cur.oe},  cur.tag);
            cmp("dq_o",  {7'd0, rtc_dq_o},  {7'd0, cur.dq},  cur.tag);
            cmp("ready", {7'd0, req_ready}, {7'd0, cur.rdy}, "R8");
            cmp("done",  {7'd0, rsp_done},  {7'd0, cur.dn},  "R8");
            cmp("rdata", rsp_rdata, cur.rd8, cur.tag);
            // R9: no overlap of the strobes, and no strobe without chip select.
            if ((!rtc_wr_n && !rtc_rd_n) || ((!rtc_wr_n || !rtc_rd_n) && rtc_cs_n)) begin
                fails++;
                $display("FAIL R9 strobes: actual cs%b wr%b rd%b expected no overlap", rtc_cs_n, rtc_wr_n, rtc_rd_n);
            end
        end
    end

    task automatic issue(bit rs, bit wr, logic [3:0] a, logic [7:0] d, logic [7:0] dev);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        dev_byte   = dev;
        rd_cnt     = 0;
        req_resync = rs;
        req_write  = wr;
        req_addr   = a;
        req_wdata  = d;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_val(string t, logic [7:0] act, logic [7:0] exp);
        vectors++;
        cmp("value", act, exp, t);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        end
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1", rsp_rdata, 8'h00);   // reset value of the read data
        check_val("R1", {7'd0, req_ready}, 8'h01);

        issue(0, 1, 4'h3, 8'hA5, 8'h00);    // R2 / R3 write frame
        wait_idle();
        issue(0, 0, 4'h3, 8'h00, 8'h3C);    // R4 read frame
        wait_idle();
        check_val("R4", rsp_rdata, 8'h3C);

        issue(0, 1, 4'hE, 8'hFF, 8'h00);    // R5 command, write flag set
        wait_idle();
        issue(0, 0, 4'hD, 8'h00, 8'h00);    // R5 command, read flag set
        wait_idle();

        issue(1, 0, 4'h5, 8'h00, 8'hFF);    // R7 resync, data discarded
        wait_idle();
        check_val("R7", rsp_rdata, 8'h3C);

        // R8: back-to-back requests, the second taken in the done cycle.
        issue(0, 0, 4'h9, 8'h00, 8'hC3);
        issue(0, 1, 4'h0, 8'h00, 8'h00);
        wait_idle();
        check_val("R8", rsp_rdata, 8'hC3);

        // R10: request fields and valid change while busy.
        tag_override = "R10";
        issue(0, 0, 4'h5, 8'h00, 8'h81);
        tag_override = "";
        repeat (7) @(negedge clk);
        req_addr   = 4'hA;
        req_wdata  = 8'h5A;
        req_write  = 1'b1;
        req_resync = 1'b1;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        req_resync = 1'b0;
        wait_idle();
        check_val("R10", rsp_rdata, 8'h81);

        issue(0, 1, 4'hB, 8'hFF, 8'h00);    // R3 all-ones write
        wait_idle();
        issue(0, 0, 4'h1, 8'h00, 8'h00);    // R4 read of all zeros
        wait_idle();
        check_val("R4", rsp_rdata, 8'h00);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule